// File: doc/BRIEF.md
# Byte-Lane Word Memory Slave with Delayed Acknowledge

This block is a small word-organised memory. It sits on an asynchronous, strobe-based processor bus that uses a handshake. The master puts a word address on the bus and drives the read/write line. It then pulls the address strobe low, together with one or both data strobes: one strobe for each byte lane. The slave checks the upper address bits against a base window set at build time. If the address falls outside that window, the slave takes no part in the cycle: the data outputs and the acknowledge stay undriven.

When a cycle is selected, the slave waits a set number of clocks, given by `WAIT_CLKS`. It then does the access and pulls its active-low acknowledge low. On a write it stores only the byte lanes that the data strobes select. On a read it drives the stored word, and it enables the output drivers only for the selected lanes. The acknowledge and the read drive stay active until the master raises the address strobe, and then both are released. A new access needs a new low phase of the strobe. If the strobe rises before the acknowledge, the cycle is abandoned and no write is done.

All bus inputs pass through one register stage before the control logic sees them. The storage holds one array per byte lane, with a registered read port, so that it maps onto block RAM with byte enables.

Top module: `memslave_top`

## Requirements
- R1: During and after reset, `ack_n` is 1, `ack_oe` is 0 and `dout_oe` is 2'b00 until a selected cycle occurs.
- R2: A cycle is answered only when `addr[ADDR_W-1:LOCAL_W]` equals `BASE`. For any other address, `ack_oe`, `ack_n` and `dout_oe` stay at their idle values.
- R3: No cycle is answered while `as_n` is 1, or while both `uds_n` and `lds_n` are 1.
- R4: Take the first rising clock edge after a selected request is placed on the inputs as edge 1. Then `ack_oe` goes to 1 after edge 2, and `ack_n` goes to 0 after edge `WAIT_CLKS`+3.
- R5: A read returns the word last written at the addressed location. `dout_oe[1]` is set only when `uds_n` is 0 and enables `dout[15:8]`. `dout_oe[0]` is set only when `lds_n` is 0 and enables `dout[7:0]`. The lane enables become active in the same cycle as `ack_n`.
- R6: A write with both strobes low (`rw`=0) stores the whole `din` word at the addressed location.
- R7: A write with only one strobe low stores only that byte lane. The other byte of the word keeps its previous value.
- R8: Raising `as_n` returns `ack_n` to 1, and `ack_oe` and `dout_oe` to 0, after the second rising edge that follows the change.
- R9: While `as_n` stays low after the acknowledge, `ack_n` stays 0 with no gap. After release, the acknowledge appears again only for a new low phase of `as_n`.
- R10: If `as_n` rises before the acknowledge has been given, no acknowledge follows and a write cycle leaves the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper byte-lane strobe, active low |
| lds_n | input | 1 | Lower byte-lane strobe, active low |
| rw | input | 1 | 1 = read (slave drives data), 0 = write |
| addr | input | ADDR_W | Word address |
| din | input | 16 | Write data from the bus |
| dout | output | 16 | Read data to the bus |
| dout_oe | output | 2 | Per-lane drive enable for `dout` (bit 1 = upper lane) |
| ack_n | output | 1 | Transfer acknowledge, active low |
| ack_oe | output | 1 | Drive enable for `ack_n` while the slave is selected |

## Verification
Assertions check on every clock that the lane drive only appears together with the acknowledge, and that the acknowledge is only driven while its output enable is set. They also check that the wait counter stays within its limit, that the acknowledge holds steadily while the strobe stays low, that release follows a captured strobe rise, that a selection only starts from a window hit, and that a write never has an empty lane mask. Other behaviour can only be shown by the bench's scenarios, with a behavioural model compared each clock. This covers the exact clock on which the acknowledge falls for two wait settings, the preservation of the other byte on lane writes, read-back contents, and misses outside the window. It also covers strobes that never open a lane, and cycles abandoned before the acknowledge.

// File: rtl/memslave_pkg.sv
package memslave_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_ACK  = 2'd2
  } slv_state_e;
endpackage

// File: rtl/memslave_decode.sv
module memslave_decode #(
  parameter int ADDR_W  = 23,
  parameter int LOCAL_W = 6,
  parameter int BASE    = 5
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic               hit,
  output logic [LOCAL_W-1:0] word_idx
);
  localparam int TAG_W = ADDR_W - LOCAL_W;

  assign hit      = (addr[ADDR_W-1:LOCAL_W] == TAG_W'(BASE));
  assign word_idx = addr[LOCAL_W-1:0];
endmodule

// File: rtl/memslave_ram.sv
module memslave_ram #(
  parameter int LOCAL_W = 6,
  parameter int DATA_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LOCAL_W-1:0]    idx,
  input  logic                  we,
  input  logic                  re,
  input  logic [DATA_W/8-1:0]   lane_we,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata
);
  localparam int LANES = DATA_W / 8;
  localparam int DEPTH = 1 << LOCAL_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] mem_l [DEPTH];
    always_ff @(posedge clk) begin
      if (we && lane_we[l]) mem_l[idx] <= wdata[8*l +: 8];
      if (re) rdata[8*l +: 8] <= mem_l[idx];
    end
  end

  // R7: a write always carries at least one lane
  p_lane_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
    we |-> (lane_we != '0));
  // R5: reads and writes never collide
  p_rd_wr_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(we && re));
endmodule

// File: rtl/memslave_ctrl.sv
module memslave_ctrl
  import memslave_pkg::*;
#(
  parameter int WAIT_CLKS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       as_q,
  input  logic       uds_q,
  input  logic       lds_q,
  input  logic       rw_q,
  input  logic       hit,
  output logic       start,
  output logic       mem_we,
  output logic       mem_re,
  output logic [1:0] lane_sel,
  output logic [1:0] lane_oe,
  output logic       ack_n,
  output logic       ack_oe
);
  localparam int CW = (WAIT_CLKS > 0) ? $clog2(WAIT_CLKS + 1) : 1;

  slv_state_e st;
  logic [CW-1:0] cnt;
  logic          rw_r;
  logic          go;

  assign start    = (st == ST_IDLE) && !as_q && hit && (!uds_q || !lds_q);
  assign go       = (st == ST_BUSY) && !as_q && (cnt == '0);
  assign mem_we   = go && !rw_r;
  assign mem_re   = go && rw_r;
  assign ack_oe   = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      rw_r     <= 1'b1;
      lane_sel <= 2'b00;
      lane_oe  <= 2'b00;
      ack_n    <= 1'b1;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st       <= ST_BUSY;
          cnt      <= CW'(WAIT_CLKS);
          rw_r     <= rw_q;
          lane_sel <= {~uds_q, ~lds_q};
        end
        ST_BUSY: begin
          if (as_q) begin
            st <= ST_IDLE;
          end else if (cnt == '0) begin
            st      <= ST_ACK;
            ack_n   <= 1'b0;
            lane_oe <= rw_r ? lane_sel : 2'b00;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_ACK: if (as_q) begin
          st      <= ST_IDLE;
          ack_n   <= 1'b1;
          lane_oe <= 2'b00;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R5: lanes are driven only alongside the acknowledge
  p_oe_with_ack_r5: assert property (@(posedge clk) disable iff (rst)
    (lane_oe != 2'b00) |-> !ack_n);
  // R1: a low acknowledge is always driven
  p_ack_driven_r1: assert property (@(posedge clk) disable iff (rst)
    !ack_n |-> ack_oe);
  // R4: wait counter bounded
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BUSY) |-> (cnt <= CW'(WAIT_CLKS)));
  // R9: acknowledge holds while strobe stays low
  p_ack_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ACK && !as_q) |=> !ack_n);
  // R8: captured strobe rise releases everything
  p_release_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ACK && as_q) |=> (ack_n && lane_oe == 2'b00 && !ack_oe));
  // R2: selection begins only from a window hit with strobe low
  p_start_hit_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_oe) |-> $past(hit && !as_q));
endmodule

// File: rtl/memslave_top.sv
module memslave_top #(
  parameter int ADDR_W    = 23,
  parameter int LOCAL_W   = 6,
  parameter int BASE      = 5,
  parameter int WAIT_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              as_n,
  input  logic              uds_n,
  input  logic              lds_n,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       din,
  output logic [15:0]       dout,
  output logic [1:0]        dout_oe,
  output logic              ack_n,
  output logic              ack_oe
);
  logic              as_q, uds_q, lds_q, rw_q;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       din_q;
  logic              hit, start, mem_we, mem_re;
  logic [LOCAL_W-1:0] word_idx, idx_r;
  logic [1:0]        lane_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      as_q   <= 1'b1;
      uds_q  <= 1'b1;
      lds_q  <= 1'b1;
      rw_q   <= 1'b1;
      addr_q <= '0;
      din_q  <= '0;
      idx_r  <= '0;
    end else begin
      as_q   <= as_n;
      uds_q  <= uds_n;
      lds_q  <= lds_n;
      rw_q   <= rw;
      addr_q <= addr;
      din_q  <= din;
      if (start) idx_r <= word_idx;
    end
  end

  memslave_decode #(.ADDR_W(ADDR_W), .LOCAL_W(LOCAL_W), .BASE(BASE)) u_dec (
    .addr(addr_q), .hit(hit), .word_idx(word_idx)
  );

  memslave_ctrl #(.WAIT_CLKS(WAIT_CLKS)) u_ctrl (
    .clk(clk), .rst(rst), .as_q(as_q), .uds_q(uds_q), .lds_q(lds_q),
    .rw_q(rw_q), .hit(hit), .start(start), .mem_we(mem_we), .mem_re(mem_re),
    .lane_sel(lane_sel), .lane_oe(dout_oe), .ack_n(ack_n), .ack_oe(ack_oe)
  );

  memslave_ram #(.LOCAL_W(LOCAL_W), .DATA_W(16)) u_ram (
    .clk(clk), .rst(rst), .idx(idx_r), .we(mem_we), .re(mem_re),
    .lane_we(lane_sel), .wdata(din_q), .rdata(dout)
  );
endmodule

// File: tb/memslave_top_tb.sv
module memslave_top_tb;
  localparam int AW = 23;
  localparam int LW = 6;
  localparam int BASE_A = 5;
  localparam int BASE_B = 6;
  localparam int WAIT_A = 3;
  localparam int WAIT_B = 0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1, rw = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0]   din = '0;
  logic [15:0]   dout_a, dout_b;
  logic [1:0]    oe_a, oe_b;
  logic          ackn_a, ackn_b, ackoe_a, ackoe_b;

  int checks = 0;
  int fails  = 0;
  logic [15:0] mdl   [2][64];
  logic [1:0]  known [2][64];

  always #2 clk = ~clk;

  memslave_top #(.ADDR_W(AW), .LOCAL_W(LW), .BASE(BASE_A), .WAIT_CLKS(WAIT_A)) u_dut (
    .clk(clk), .rst(rst), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n), .rw(rw),
    .addr(addr), .din(din), .dout(dout_a), .dout_oe(oe_a), .ack_n(ackn_a), .ack_oe(ackoe_a)
  );
  memslave_top #(.ADDR_W(AW), .LOCAL_W(LW), .BASE(BASE_B), .WAIT_CLKS(WAIT_B)) u_dut_z (
    .clk(clk), .rst(rst), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n), .rw(rw),
    .addr(addr), .din(din), .dout(dout_b), .dout_oe(oe_b), .ack_n(ackn_b), .ack_oe(ackoe_b)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare both slaves against the model at one sampling point
  task automatic compare_all(input int who, input bit resp, input bit rd, input logic [1:0] ln,
                             input int idx, input int step, input string req);
    for (int d = 0; d < 2; d++) begin
      int  w       = (d == 0) ? WAIT_A : WAIT_B;
      bit  me      = resp && (d == who);
      bit  e_oe    = me && step >= 2;
      bit  e_ack   = me && step >= w + 3;
      logic [1:0] e_lanes = (e_ack && rd) ? ln : 2'b00;
      logic       a_ackn  = (d == 0) ? ackn_a : ackn_b;
      logic       a_ackoe = (d == 0) ? ackoe_a : ackoe_b;
      logic [1:0] a_oe    = (d == 0) ? oe_a : oe_b;
      logic [15:0] a_dq   = (d == 0) ? dout_a : dout_b;
      check(a_ackoe == e_oe, req, int'(a_ackoe), int'(e_oe));
      check(a_ackn == !e_ack, req, int'(a_ackn), int'(!e_ack));
      check(a_oe == e_lanes, req, int'(a_oe), int'(e_lanes));
      for (int l = 0; l < 2; l++)
        if (e_lanes[l] && known[d][idx][l])
          check(a_dq[8*l +: 8] == mdl[d][idx][8*l +: 8], {req, " R5 data"},
                int'(a_dq[8*l +: 8]), int'(mdl[d][idx][8*l +: 8]));
    end
  endtask

  // one strobe cycle held for 'cyc' clocks, then released and watched
  task automatic bus_cycle(input int base, input int idx, input bit rd, input bit up, input bit lo,
                           input logic [15:0] wdata, input int cyc, input string req);
    int who = (base == BASE_A) ? 0 : (base == BASE_B) ? 1 : 2;
    int w   = (who == 1) ? WAIT_B : WAIT_A;
    bit resp = (who < 2) && (up || lo);
    logic [1:0] ln = {up, lo};
    @(negedge clk);
    addr = AW'((base << LW) | idx);
    rw = rd; din = wdata; uds_n = !up; lds_n = !lo; as_n = 1'b0;
    for (int k = 1; k <= cyc; k++) begin
      @(posedge clk); @(negedge clk);
      compare_all(who, resp, rd, ln, idx, k, req);
    end
    as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
    @(posedge clk); @(negedge clk);
    compare_all(who, resp, rd, ln, idx, cyc + 1, {req, " R8"});
    for (int k = 0; k < 2; k++) begin
      @(posedge clk); @(negedge clk);
      compare_all(who, 1'b0, rd, ln, idx, 0, {req, " R8"});
    end
    if (resp && !rd && cyc + 1 >= w + 3)
      for (int l = 0; l < 2; l++)
        if (ln[l]) begin
          mdl[who][idx][8*l +: 8] = wdata[8*l +: 8];
          known[who][idx][l] = 1'b1;
        end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int d = 0; d < 2; d++) for (int i = 0; i < 64; i++) known[d][i] = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare_all(0, 1'b0, 1'b0, 2'b00, 0, 0, "R1 reset");
    rst = 1'b0;
    @(negedge clk);
    compare_all(0, 1'b0, 1'b0, 2'b00, 0, 0, "R1 idle");

    // R6 word writes then reads, both wait settings
    bus_cycle(BASE_A, 3, 1'b0, 1, 1, 16'hA1B2, 8, "R6 wr A");
    bus_cycle(BASE_A, 3, 1'b1, 1, 1, 16'h0000, 8, "R4 R5 rd A");
    bus_cycle(BASE_B, 3, 1'b0, 1, 1, 16'h1234, 5, "R6 wr B");
    bus_cycle(BASE_B, 3, 1'b1, 1, 1, 16'h0000, 5, "R4 R5 rd B");
    bus_cycle(BASE_A, 63, 1'b0, 1, 1, 16'hFFFF, 7, "R6 top idx");
    bus_cycle(BASE_A, 0, 1'b0, 1, 1, 16'h0001, 7, "R6 idx0");
    bus_cycle(BASE_A, 63, 1'b1, 1, 1, 16'h0000, 7, "R5 top idx");
    // R7 byte writes keep other lane
    bus_cycle(BASE_A, 3, 1'b0, 1, 0, 16'h5A00, 7, "R7 upper wr");
    bus_cycle(BASE_A, 3, 1'b1, 1, 1, 16'h0000, 7, "R7 readback");
    bus_cycle(BASE_B, 3, 1'b0, 0, 1, 16'h00C3, 4, "R7 lower wr");
    bus_cycle(BASE_B, 3, 1'b1, 1, 1, 16'h0000, 4, "R7 readback B");
    // R5 byte reads drive one lane only
    bus_cycle(BASE_A, 3, 1'b1, 0, 1, 16'h0000, 7, "R5 lower rd");
    bus_cycle(BASE_B, 3, 1'b1, 1, 0, 16'h0000, 4, "R5 upper rd");
    // R2 outside the window
    bus_cycle(7, 3, 1'b0, 1, 1, 16'hDEAD, 8, "R2 miss wr");
    bus_cycle(0, 3, 1'b1, 1, 1, 16'h0000, 8, "R2 miss rd");
    bus_cycle(BASE_A, 3, 1'b1, 1, 1, 16'h0000, 7, "R2 unchanged");
    // R3 no data strobe
    bus_cycle(BASE_A, 3, 1'b0, 0, 0, 16'h7777, 8, "R3 no strobe");
    bus_cycle(BASE_A, 3, 1'b1, 1, 1, 16'h0000, 7, "R3 unchanged");
    // R9 long hold, then back to back
    bus_cycle(BASE_A, 63, 1'b1, 1, 1, 16'h0000, 20, "R9 long hold");
    bus_cycle(BASE_A, 63, 1'b1, 1, 1, 16'h0000, 6, "R9 next cycle");
    // R10 aborted writes (raised before the access point)
    bus_cycle(BASE_A, 3, 1'b0, 1, 1, 16'hBAD0, 2, "R10 abort");
    bus_cycle(BASE_A, 3, 1'b0, 1, 1, 16'hBAD1, 4, "R10 abort late");
    bus_cycle(BASE_A, 3, 1'b1, 1, 1, 16'h0000, 7, "R10 unchanged");
    bus_cycle(BASE_B, 0, 1'b0, 1, 1, 16'h4242, 1, "R10 abort B");
    bus_cycle(BASE_B, 0, 1'b1, 1, 1, 16'h0000, 4, "R10 rd B");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule